// File: doc/BRIEF.md
# Address-Framed Serial Control Slave

This block is the control port of a tuner-style synthesizer. A host drives four lines: chip-enable, a serial clock, serial data in, and an open-drain data-out line. Each transfer begins with an 8-bit address, which the host clocks in while chip-enable is low. Chip-enable then rises, and the address picks one of three things: a write to configuration word A, a write to configuration word B, or a read of a 23-bit status word. All lines are sampled on the system clock through synchronisers, so the serial clock must be much slower than the system clock.

A write shifts in 24 bits. Both configuration words stay unchanged until chip-enable falls, and only a frame that carried at least 24 bits is committed. A read captures the port pins, the lock state and a 20-bit count when chip-enable rises, then shifts that word out MSB first. Between transfers, the data-out line acts as a status pin, selected by a 3-bit field of word B. A sticky unlock flag is set by a pulse from the phase detector, and it is cleared when a recognised transfer ends.

The serial link has no back-pressure. The host sets the pace with its clock, and the block keeps up as long as each serial clock level lasts at least four system cycles. All status inputs are plain level pins.

Top module: `sctl_slave`

## Requirements
- R1: The address is the last 8 bits sampled on serial-clock rising edges while chip-enable is low, with the first bit sent taken as bit 0. The value 0x28 (sent as 0,0,0,1,0,1,0,0) selects word A, 0x29 selects word B and 0x2A selects read mode.
- R2: In a write frame, bits are sampled on serial-clock rising edges while chip-enable is high. The first bit lands in bit 0 of the word and the 24th bit in bit 23. In word B, bits 11:9 form the data-out select field (bit 11 is the MSB), bit 0 sets port 1 as an output and bit 1 sets port 2 as an output.
- R3: A configuration word changes only when chip-enable falls. The write is discarded if fewer than 24 bits were clocked in, and any bit after the 24th is ignored.
- R4: A frame with any other address changes no register, leaves the unlock flag as it was, and keeps data-out open while chip-enable is high.
- R5: In read mode, the word {port2 pin, port1 pin, lock bit, count[19:0]} is captured when chip-enable rises and sent MSB first. A 1 bit leaves data-out open and a 0 bit pulls it low. The bit advances on each serial-clock falling edge that follows a rising edge in the same frame. After all 23 bits, data-out stays open.
- R6: Transfers work whether the serial clock idles high or low.
- R7: Data-out is open during a write frame, whatever the select field holds.
- R8: The unlock flag is set by an unlock pulse and holds until a recognised frame ends (chip-enable falls). It reads as lock bit 0 while set. A pulse wins over a clear in the same cycle.
- R9: Outside transfers, the select field sets data-out: 001 pulls low while the unlock flag is set, 010 pulls low while count-done is high, 101 follows the port 1 pin, 110 follows the port 2 pin, and 000, 011, 100 and 111 leave it open.
- R10: Under select 101 or 110, data-out stays open when the matching port is set as an output.
- R11: After reset, word A is 0x080000 (only the crystal-select bit 19 set), word B is 0, the unlock flag is clear and data-out is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Chip-enable line |
| sck | input | 1 | Serial clock line |
| sdi | input | 1 | Serial data in |
| io1_pin | input | 1 | Port 1 pin level |
| io2_pin | input | 1 | Port 2 pin level |
| unlock_evt | input | 1 | Unlock detected pulse |
| count_done | input | 1 | Count measurement complete |
| count_val | input | 20 | Current count value |
| sdo_low | output | 1 | 1 pulls data-out low, 0 leaves it open |
| cfg_a | output | 24 | Configuration word A |
| cfg_b | output | 24 | Configuration word B |

## Verification
The assertions check on every cycle that:
- the configuration words hold still except on a chip-enable fall;
- data-out stays open during write frames and unknown-address frames;
- the unlock flag survives until a recognised frame ends;
- the bit counter stays within range;
- the read shifter holds between clock falls and refills with open bits.

Other behaviour needs the bench's scenarios to show it:
- address decoding;
- the bit order in both directions;
- discarding of short frames;
- capture of the status word when chip-enable rises;
- both clock idle levels;
- each code of the data-out select field.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int ADDR_W  = 8;
  localparam int WORD_W  = 24;
  localparam int CNT_W   = 20;
  localparam int DOC_LSB = 9;
  localparam int IOC1_BIT = 0;
  localparam int IOC2_BIT = 1;
  localparam int XS_BIT  = 19;
  localparam logic [ADDR_W-1:0] ADR_WR_A = 8'h28;
  localparam logic [ADDR_W-1:0] ADR_WR_B = 8'h29;
  localparam logic [ADDR_W-1:0] ADR_RD   = 8'h2A;

  typedef enum logic [1:0] {FR_NONE, FR_WR_A, FR_WR_B, FR_RD} frame_e;

  typedef enum logic [2:0] {
    SEL_OPEN0 = 3'b000, SEL_UNLOCK = 3'b001, SEL_DONE = 3'b010,
    SEL_OPEN3 = 3'b011, SEL_OPEN4 = 3'b100, SEL_PORT1 = 3'b101,
    SEL_PORT2 = 3'b110, SEL_OPEN7 = 3'b111
  } dout_sel_e;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_in[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sctl_rx.sv
module sctl_rx
  import sctl_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W,
  parameter int WORD_W_P = WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_q,
  input  logic                ce_rise,
  input  logic                ce_fall,
  input  logic                sck_rise,
  input  logic                sdi_q,
  output frame_e              frame,
  output logic                wr_a_stb,
  output logic                wr_b_stb,
  output logic                frame_end,
  output logic [WORD_W_P-1:0] wr_data
);
  localparam int CW = $clog2(WORD_W_P + 1);
  localparam logic [CW-1:0] FULL = CW'(WORD_W_P);

  logic [ADDR_W_P-1:0] adr_sr;
  logic [CW-1:0]       bit_cnt;

  function automatic frame_e decode(input logic [ADDR_W_P-1:0] a);
    if (a == ADDR_W_P'(ADR_WR_A))      return FR_WR_A;
    else if (a == ADDR_W_P'(ADR_WR_B)) return FR_WR_B;
    else if (a == ADDR_W_P'(ADR_RD))   return FR_RD;
    else                               return FR_NONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_sr  <= '0;
      wr_data <= '0;
      bit_cnt <= '0;
      frame   <= FR_NONE;
    end else begin
      if (!ce_q && sck_rise) adr_sr <= {sdi_q, adr_sr[ADDR_W_P-1:1]};
      if (ce_rise) begin
        frame   <= decode(adr_sr);
        bit_cnt <= '0;
      end else if (ce_q && sck_rise && bit_cnt < FULL) begin
        wr_data <= {sdi_q, wr_data[WORD_W_P-1:1]};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (ce_fall) frame <= FR_NONE;
    end
  end

  assign wr_a_stb  = ce_fall && (frame == FR_WR_A) && (bit_cnt == FULL);
  assign wr_b_stb  = ce_fall && (frame == FR_WR_B) && (bit_cnt == FULL);
  assign frame_end = ce_fall && (frame != FR_NONE);

  // R3: the bit counter never passes the word length
  a_r3_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= FULL);
  // R1: every frame is closed by the chip-enable fall
  a_r1_frame_close: assert property (@(posedge clk) disable iff (!rst_n)
    ce_fall |=> frame == FR_NONE);
endmodule

// File: rtl/sctl_tx.sv
module sctl_tx #(
  parameter int RD_W = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_q,
  input  logic            ce_rise,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic [RD_W-1:0] rd_word,
  output logic            bit_out
);
  logic [RD_W-1:0] sr;
  logic            armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '1;
      armed <= 1'b0;
    end else if (ce_rise) begin
      sr    <= rd_word;
      armed <= 1'b0;
    end else if (ce_q) begin
      if (sck_rise) armed <= 1'b1;
      if (sck_fall && armed) sr <= {sr[RD_W-2:0], 1'b1};
    end
  end

  assign bit_out = sr[RD_W-1];

  // R5: the shifter only moves on a qualified falling edge or a new load
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_rise && !sck_fall) |=> $stable(sr));
  // R5: bits past the end of the word read as open
  a_r5_tail_open: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && !ce_rise && sck_fall && armed) |=> sr[0]);
endmodule

// File: rtl/sctl_slave.sv
module sctl_slave
  import sctl_pkg::*;
#(
  parameter int ADDR_W_P    = ADDR_W,
  parameter int WORD_W_P    = WORD_W,
  parameter int CNT_W_P     = CNT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                sck,
  input  logic                sdi,
  input  logic                io1_pin,
  input  logic                io2_pin,
  input  logic                unlock_evt,
  input  logic                count_done,
  input  logic [CNT_W_P-1:0]  count_val,
  output logic                sdo_low,
  output logic [WORD_W_P-1:0] cfg_a,
  output logic [WORD_W_P-1:0] cfg_b
);
  localparam int RD_W = CNT_W_P + 3;
  localparam logic [WORD_W_P-1:0] RST_A = WORD_W_P'(1) << XS_BIT;
  localparam logic [WORD_W_P-1:0] RST_B = '0;

  logic [4:0] sq;
  logic ce_q, sck_q, sdi_q, io1_q, io2_q;
  logic ce_d, sck_d, ce_rise, ce_fall, sck_rise, sck_fall;
  frame_e frame;
  logic wr_a_stb, wr_b_stb, frame_end, tx_bit, unl_flag;
  logic [WORD_W_P-1:0] wr_data;
  dout_sel_e sel;

  sctl_sync #(.N(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({io2_pin, io1_pin, sdi, sck, ce}), .q(sq));

  assign {io2_q, io1_q, sdi_q, sck_q, ce_q} = sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d  <= 1'b0;
      sck_d <= 1'b0;
    end else begin
      ce_d  <= ce_q;
      sck_d <= sck_q;
    end
  end

  assign ce_rise  =  ce_q  & ~ce_d;
  assign ce_fall  = ~ce_q  &  ce_d;
  assign sck_rise =  sck_q & ~sck_d;
  assign sck_fall = ~sck_q &  sck_d;

  sctl_rx #(.ADDR_W_P(ADDR_W_P), .WORD_W_P(WORD_W_P)) u_rx (
    .clk(clk), .rst_n(rst_n), .ce_q(ce_q), .ce_rise(ce_rise),
    .ce_fall(ce_fall), .sck_rise(sck_rise), .sdi_q(sdi_q),
    .frame(frame), .wr_a_stb(wr_a_stb), .wr_b_stb(wr_b_stb),
    .frame_end(frame_end), .wr_data(wr_data));

  sctl_tx #(.RD_W(RD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .ce_q(ce_q), .ce_rise(ce_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .rd_word({io2_q, io1_q, ~unl_flag, count_val}), .bit_out(tx_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a    <= RST_A;
      cfg_b    <= RST_B;
      unl_flag <= 1'b0;
    end else begin
      if (wr_a_stb) cfg_a <= wr_data;
      if (wr_b_stb) cfg_b <= wr_data;
      if (unlock_evt)     unl_flag <= 1'b1;
      else if (frame_end) unl_flag <= 1'b0;
    end
  end

  assign sel = dout_sel_e'(cfg_b[DOC_LSB +: 3]);

  always_comb begin
    sdo_low = 1'b0;
    if (ce_q) begin
      if (frame == FR_RD) sdo_low = ~tx_bit;
    end else begin
      unique case (sel)
        SEL_UNLOCK: sdo_low = unl_flag;
        SEL_DONE:   sdo_low = count_done;
        SEL_PORT1:  sdo_low = ~cfg_b[IOC1_BIT] & ~io1_q;
        SEL_PORT2:  sdo_low = ~cfg_b[IOC2_BIT] & ~io2_q;
        default:    sdo_low = 1'b0;
      endcase
    end
  end

  // R3: configuration words move only on a chip-enable fall
  a_r3_latch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_fall |=> ($stable(cfg_a) && $stable(cfg_b)));
  // R7: data-out is released during write frames
  a_r7_write_open: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && (frame == FR_WR_A || frame == FR_WR_B)) |-> !sdo_low);
  // R4: unknown-address frames keep data-out released
  a_r4_unknown_open: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && frame == FR_NONE) |-> !sdo_low);
  // R8: the unlock flag persists until a recognised frame ends
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unl_flag && !frame_end) |=> unl_flag);
endmodule

// File: tb/sctl_slave_tb.sv
module sctl_slave_tb;
  localparam int HP = 60;
  localparam int NV = 6;
  localparam logic [7:0]  V_ADDR [NV] = '{8'h28, 8'h29, 8'h28, 8'h55, 8'h28, 8'h29};
  localparam int          V_N    [NV] = '{24, 24, 20, 24, 30, 24};
  localparam logic [31:0] V_DATA [NV] = '{32'h00123456, 32'h00000A05, 32'h000FFFFF,
                                          32'h00FFFFFF, 32'hFFABCDEF, 32'h00000000};
  localparam logic [23:0] V_EA   [NV] = '{24'h123456, 24'h123456, 24'h123456,
                                          24'h123456, 24'hABCDEF, 24'hABCDEF};
  localparam logic [23:0] V_EB   [NV] = '{24'h000000, 24'h000A05, 24'h000A05,
                                          24'h000A05, 24'h000A05, 24'h000000};
  localparam bit          V_IDLE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sck = 1'b0, sdi = 1'b0, io1 = 1'b0, io2 = 1'b0;
  logic unl = 1'b0, cdone = 1'b0;
  logic [19:0] cval = '0;
  logic sdo_low;
  logic [23:0] cfg_a, cfg_b;
  int checks = 0, errors = 0;
  bit idle_hi = 1'b0, done = 1'b0;
  logic [31:0] got;

  always #5 clk = ~clk;

  sctl_slave u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sck(sck), .sdi(sdi),
    .io1_pin(io1), .io2_pin(io2), .unlock_evt(unl), .count_done(cdone),
    .count_val(cval), .sdo_low(sdo_low), .cfg_a(cfg_a), .cfg_b(cfg_b));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    if (idle_hi) begin sck = 1'b0; #(HP); sck = 1'b1; #(HP); end
    else         begin sck = 1'b1; #(HP); sck = 1'b0; #(HP); end
  endtask

  task automatic send_addr(input logic [7:0] a);
    sck = idle_hi; #(HP);
    for (int i = 0; i < 8; i++) begin sdi = a[i]; pulse(); end
  endtask

  task automatic write_frame(input logic [7:0] a, input int n, input logic [31:0] d);
    send_addr(a);
    ce = 1'b1; #(HP);
    for (int i = 0; i < n; i++) begin sdi = d[i]; pulse(); end
    ce = 1'b0; #(2*HP);
  endtask

  task automatic read_frame(input int n, input logic n_io1, input logic n_io2,
                            input logic [19:0] n_cval, output logic [31:0] word);
    word = '0;
    send_addr(8'h2A);
    ce = 1'b1; #(HP);
    io1 = n_io1; io2 = n_io2; cval = n_cval;
    for (int k = 0; k < n; k++) begin
      if (idle_hi) begin
        sck = 1'b0; #(HP); sck = 1'b1; #(HP);
        word[n-1-k] = ~sdo_low;
      end else begin
        sck = 1'b1; #(HP);
        word[n-1-k] = ~sdo_low;
        sck = 1'b0; #(HP);
      end
    end
    ce = 1'b0; #(2*HP);
  endtask

  task automatic unlock_pulse();
    unl = 1'b1; #10; unl = 1'b0; #(HP);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #100; rst_n = 1'b1; #100;
    // R11 reset state
    check("R11 cfg_a reset", cfg_a, 32'h080000);
    check("R11 cfg_b reset", cfg_b, 32'h0);
    check("R11 sdo open", sdo_low, 0);

    // Table walk: R1 address decode, R2 bit order, R3 short/long frames,
    // R4 unknown address, R6 idle polarity, R10 port output forces open
    for (int i = 0; i < NV; i++) begin
      idle_hi = V_IDLE[i];
      write_frame(V_ADDR[i], V_N[i], V_DATA[i]);
      check($sformatf("R1/R2/R3/R4/R6 vec%0d cfg_a", i), cfg_a, V_EA[i]);
      check($sformatf("R1/R2/R3/R4/R6 vec%0d cfg_b", i), cfg_b, V_EB[i]);
      check($sformatf("R9/R10 vec%0d sdo", i), sdo_low, 0);
    end

    // R8 / R9 select 001 follows the sticky unlock flag
    idle_hi = 1'b0;
    write_frame(8'h29, 24, 32'h000200);
    unlock_pulse(); #(4*HP);
    check("R8 sticky unlock drives low", sdo_low, 1);

    // R7 write frame keeps data-out open, R8 frame end clears flag
    send_addr(8'h28); ce = 1'b1; #(HP);
    check("R7 open during write", sdo_low, 0);
    for (int i = 0; i < 24; i++) begin sdi = (i % 4 == 0); pulse(); end
    ce = 1'b0; #(2*HP);
    check("R2 cfg_a from directed write", cfg_a, 32'h111111);
    check("R8 flag cleared by write frame", sdo_low, 0);

    // R4 unknown frame: open while active, flag untouched
    unlock_pulse();
    send_addr(8'h00); ce = 1'b1; #(HP);
    check("R4 open during unknown frame", sdo_low, 0);
    for (int i = 0; i < 24; i++) begin sdi = 1'b1; pulse(); end
    ce = 1'b0; #(2*HP);
    check("R4 flag kept after unknown frame", sdo_low, 1);
    check("R4 cfg_a kept", cfg_a, 32'h111111);

    // R5 read, idle low, pins change after capture
    io1 = 1'b1; io2 = 1'b0; cval = 20'h53980; #(2*HP);
    read_frame(23, 1'b0, 1'b1, 20'hFFFFF, got);
    check("R5 read word idle low", got, {9'd0, 1'b0, 1'b1, 1'b0, 20'h53980});
    check("R8 flag cleared by read frame", sdo_low, 0);

    // R5 / R6 read with idle-high clock and trailing open bits
    idle_hi = 1'b1;
    read_frame(26, 1'b1, 1'b0, 20'h00E10, got);
    check("R5/R6 read word idle high", got, {6'd0, 1'b1, 1'b0, 1'b1, 20'hFFFFF, 3'b111});
    idle_hi = 1'b0;

    // R9 select 010 count-done
    write_frame(8'h29, 24, 32'h000400);
    cdone = 1'b1; #(4*HP);
    check("R9 sel 010 done low", sdo_low, 1);
    cdone = 1'b0; #(4*HP);
    check("R9 sel 010 not done open", sdo_low, 0);

    // R9 select 011 stays open
    write_frame(8'h29, 24, 32'h000600);
    cdone = 1'b1; io1 = 1'b0; io2 = 1'b0; unlock_pulse(); #(4*HP);
    check("R9 sel 011 open", sdo_low, 0);
    cdone = 1'b0;

    // R9 / R10 select 101 port 1
    write_frame(8'h29, 24, 32'h000A00);
    #(4*HP);
    check("R9 sel 101 port1 low", sdo_low, 1);
    io1 = 1'b1; #(4*HP);
    check("R9 sel 101 port1 high", sdo_low, 0);
    write_frame(8'h29, 24, 32'h000A01);
    io1 = 1'b0; #(4*HP);
    check("R10 port1 output forces open", sdo_low, 0);

    // R9 / R10 select 110 port 2
    write_frame(8'h29, 24, 32'h000C00);
    #(4*HP);
    check("R9 sel 110 port2 low", sdo_low, 1);
    io2 = 1'b1; #(4*HP);
    check("R9 sel 110 port2 high", sdo_low, 0);
    write_frame(8'h29, 24, 32'h000C02);
    io2 = 1'b0; #(4*HP);
    check("R10 port2 output forces open", sdo_low, 0);
    check("R3 cfg_a untouched by word B writes", cfg_a, 32'h111111);

    done = 1'b1;
    finish_run();
  end
endmodule